// File: doc/BRIEF.md
# Priority Interrupt Controller with Level Mask

This block sits between the interrupt request lines of a processor subsystem and the CPU. It watches eight maskable request lines, ranked level 1 (highest) to level 8 (lowest), and three non-maskable lines: a non-maskable interrupt, an illegal-instruction trap and a watchdog overflow. Each rising edge on a line sets a sticky pending bit. The block picks one pending source, presents its fixed 16-bit service address together with a valid strobe, and waits until the CPU acknowledges it. The acknowledge clears that one pending bit.

The CPU supplies a 3-bit threshold code taken from its processor status register. Codes 0 and 1 admit every maskable level. Each higher code admits one level fewer, so code 7 admits only levels 1 and 2. The non-maskable sources ignore the code. A masked request stays pending and is offered once the code admits its level.

The offer handshake is a two-state machine. In `ST_IDLE` the block waits for an eligible pending source. The transition `GRANT` (ST_IDLE to ST_OFFER) registers the chosen vector and raises the strobe. `ST_OFFER` holds the vector and strobe steady. The transition `RETIRE` (ST_OFFER to ST_IDLE) is taken on acknowledge: it drops the strobe and clears the chosen pending bit. When nothing is eligible, ST_IDLE stays in ST_IDLE. Without an acknowledge, ST_OFFER stays in ST_OFFER.

Top module: `pic_level_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and holds `o_vec_valid` low. After reset is released, only a new rising edge on a request line can produce an offer.
- R2: A request line that is high for a single cycle, rising from low, is remembered as pending until it is acknowledged.
- R3: The maskable vectors are fixed. Level 1 through level 8 (`i_irq[0]` through `i_irq[7]`) map to 16'h1000, 16'h1002, 16'h1006, 16'h1008, 16'h100E, 16'h1012, 16'h1016 and 16'h101A.
- R4: The non-maskable vectors are fixed. `i_nmi` and `i_illegal` both map to 16'h101E, and `i_wdt` maps to 16'h101C. These sources are offered regardless of the mask code. The offer order is NMI first, then illegal instruction, then watchdog, then any maskable level.
- R5: Among admitted maskable requests pending together, the lowest level number is offered first.
- R6: A mask code of 0 or 1 admits levels 1–8. A code c from 2 to 7 admits levels 1 through 9−c.
- R7: A request whose level is not admitted is not offered but stays pending. It is offered once the mask code admits it.
- R8: The offer is registered. When a request rises before clock edge k, `o_vec_valid` is high after edge k+1.
- R9: While `o_vec_valid` is high and `i_ack` is low, `o_vec_addr` and `o_vec_valid` do not change, even if a higher-priority request arrives.
- R10: `i_ack` during an offer drops `o_vec_valid` at the next edge and clears only the offered source. Other pending sources are offered next, one cycle later.
- R11: `i_ack` while no offer is shown has no effect on pending requests.
- R12: A request line held high produces one offer only. No further offer occurs until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_irq | input | 8 | Maskable request lines, bit n is level n+1 |
| i_nmi | input | 1 | Non-maskable interrupt request |
| i_illegal | input | 1 | Illegal-instruction trap request |
| i_wdt | input | 1 | Watchdog overflow request |
| i_mask | input | 3 | Level threshold code from the processor status register |
| i_ack | input | 1 | CPU acknowledge of the offered vector |
| o_vec_addr | output | 16 | Service address of the offered source |
| o_vec_valid | output | 1 | Offer strobe |

## Verification
The assertions assume that `i_ack` is raised only while an offer is shown, or else has no effect. They also assume that reset is held for at least one clock edge before any checked behaviour. The stimulus drives every input just after a rising edge and holds acknowledge for exactly one cycle. Single-cycle request pulses are spaced so that each acknowledge retires a source whose line is already low. The sweeps cover every mask code against every level, and every pair of maskable levels raised together.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_FIXED    = 3;
    localparam int NUM_MASKABLE = 8;
    localparam int NUM_SRC      = NUM_FIXED + NUM_MASKABLE;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int LVL_W        = $clog2(NUM_MASKABLE + 2);
    localparam int MASK_W       = 3;
    localparam int VEC_W        = 16;

    // source index order is the service order:
    // 0 NMI, 1 illegal, 2 watchdog, 3..10 maskable levels 1..8
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } pic_state_e;

    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        unique case (idx)
            4'd0, 4'd1: v = 16'h101E;
            4'd2:       v = 16'h101C;
            4'd3:       v = 16'h1000;
            4'd4:       v = 16'h1002;
            4'd5:       v = 16'h1006;
            4'd6:       v = 16'h1008;
            4'd7:       v = 16'h100E;
            4'd8:       v = 16'h1012;
            4'd9:       v = 16'h1016;
            4'd10:      v = 16'h101A;
            default:    v = 16'h101E;
        endcase
        return v;
    endfunction

    // highest admitted maskable level for a threshold code
    function automatic logic [LVL_W-1:0] mask_limit(input logic [MASK_W-1:0] code);
        logic [LVL_W-1:0] lim;
        if (code < 3'd2) lim = LVL_W'(NUM_MASKABLE);
        else             lim = LVL_W'(NUM_MASKABLE + 1) - LVL_W'(code);
        return lim;
    endfunction

endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture
    import pic_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    // follows the lines through reset so a level held across reset is no event
    always_ff @(posedge clk) begin
        req_q <= req;
    end

    assign rise = req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            // a fresh edge wins over a same-cycle clear
            pend <= (pend & ~clr) | rise;
        end
    end

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0)); // R10

    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend & $past(rise)) == $past(rise))); // R2

endmodule

// File: rtl/pic_select.sv
module pic_select
    import pic_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [MASK_W-1:0]  mask_code,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_SRC-1:0] elig;
    logic [LVL_W-1:0]   lim;

    assign lim = mask_limit(mask_code);

    generate
        for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
            assign elig[g] = pend[g];
        end
        for (genvar g = 0; g < NUM_MASKABLE; g++) begin : g_lvl
            assign elig[NUM_FIXED+g] = pend[NUM_FIXED+g] && (LVL_W'(g + 1) <= lim);
        end
    endgenerate

    // scan from the lowest rank up so the best-ranked eligible index remains
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (elig[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/pic_offer_fsm.sv
module pic_offer_fsm
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               any,
    input  logic [IDX_W-1:0]   idx,
    input  logic               ack,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [NUM_SRC-1:0] clr
);

    pic_state_e       state, state_nx;
    logic [IDX_W-1:0] held_idx;
    logic             retire;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (any) state_nx = ST_OFFER;   // GRANT
            ST_OFFER: if (ack) state_nx = ST_IDLE;    // RETIRE
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            held_idx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any) begin
                        vec_valid <= 1'b1;
                        vec_addr  <= src_vector(idx);
                        held_idx  <= idx;
                    end
                end
                ST_OFFER: begin
                    if (ack) vec_valid <= 1'b0;
                end
                default: vec_valid <= 1'b0;
            endcase
        end
    end

    assign retire = (state == ST_OFFER) && ack;

    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            clr[k] = retire && (held_idx == IDX_W'(k));
        end
    end

    AST_OFFER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !ack) |=> (vec_valid && $stable(vec_addr))); // R9

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && ack) |=> !vec_valid); // R10

    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr)); // R10

endmodule

// File: rtl/pic_level_ctrl.sv
module pic_level_ctrl
    import pic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MASKABLE-1:0] i_irq,
    input  logic                    i_nmi,
    input  logic                    i_illegal,
    input  logic                    i_wdt,
    input  logic [MASK_W-1:0]       i_mask,
    input  logic                    i_ack,
    output logic [VEC_W-1:0]        o_vec_addr,
    output logic                    o_vec_valid
);

    logic [NUM_SRC-1:0] req_bus;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic               sel_any;
    logic [IDX_W-1:0]   sel_idx;

    assign req_bus = {i_irq, i_wdt, i_illegal, i_nmi};

    pic_edge_capture #(.N(NUM_SRC)) u_capture (
        .clk  (clk),
        .rst  (rst),
        .req  (req_bus),
        .clr  (clr),
        .pend (pend)
    );

    pic_select u_select (
        .pend      (pend),
        .mask_code (i_mask),
        .any       (sel_any),
        .idx       (sel_idx)
    );

    pic_offer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .any       (sel_any),
        .idx       (sel_idx),
        .ack       (i_ack),
        .vec_valid (o_vec_valid),
        .vec_addr  (o_vec_addr),
        .clr       (clr)
    );

    // level implied by an address on the output, 0 for non-maskable ones
    function automatic logic [LVL_W-1:0] level_of(input logic [VEC_W-1:0] a);
        logic [LVL_W-1:0] l;
        case (a)
            16'h1000: l = 4'd1;
            16'h1002: l = 4'd2;
            16'h1006: l = 4'd3;
            16'h1008: l = 4'd4;
            16'h100E: l = 4'd5;
            16'h1012: l = 4'd6;
            16'h1016: l = 4'd7;
            16'h101A: l = 4'd8;
            default:  l = 4'd0;
        endcase
        return l;
    endfunction

    AST_MASK_RESPECT: assert property (@(posedge clk) disable iff (rst)
        $rose(o_vec_valid) |-> (level_of(o_vec_addr) <= mask_limit($past(i_mask)))); // R6

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        o_vec_valid |-> (o_vec_addr inside {16'h1000, 16'h1002, 16'h1006, 16'h1008,
                                            16'h100E, 16'h1012, 16'h1016, 16'h101A,
                                            16'h101C, 16'h101E})); // R3

endmodule

// File: tb/pic_level_ctrl_tb.sv
`timescale 1ns/1ps
module pic_level_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  i_irq = '0;
    logic        i_nmi = 1'b0;
    logic        i_illegal = 1'b0;
    logic        i_wdt = 1'b0;
    logic [2:0]  i_mask = '0;
    logic        i_ack = 1'b0;
    logic [15:0] o_vec_addr;
    logic        o_vec_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] lvl_vec [8] = '{16'h1000, 16'h1002, 16'h1006, 16'h1008,
                                 16'h100E, 16'h1012, 16'h1016, 16'h101A};

    always #2.5 clk = ~clk;

    pic_level_ctrl u_dut (
        .clk(clk), .rst(rst), .i_irq(i_irq), .i_nmi(i_nmi), .i_illegal(i_illegal),
        .i_wdt(i_wdt), .i_mask(i_mask), .i_ack(i_ack),
        .o_vec_addr(o_vec_addr), .o_vec_valid(o_vec_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_offer(input string tag, input logic [15:0] v);
        chk({tag, " valid"}, 16'(o_vec_valid), 16'h1);
        chk({tag, " vector"}, o_vec_addr, v);
    endtask

    task automatic do_ack(input string tag);
        i_ack = 1'b1;
        tick();
        i_ack = 1'b0;
        chk({tag, " strobe drops on ack"}, 16'(o_vec_valid), 16'h0);
    endtask

    function automatic int limit_of(input int m);
        return (m < 2) ? 8 : 9 - m;
    endfunction

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 idle after reset", 16'(o_vec_valid), 16'h0);

        // R1: pending bit wiped by reset
        i_irq[0] = 1'b1; tick(); i_irq[0] = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        tick(); tick(); tick();
        chk("R1 pending cleared by reset", 16'(o_vec_valid), 16'h0);

        // R8 latency, R2 single-cycle pulse
        i_irq[2] = 1'b1; tick(); i_irq[2] = 1'b0;
        chk("R8 not yet valid one edge after request", 16'(o_vec_valid), 16'h0);
        tick();
        expect_offer("R8 R2 offer two edges after request", 16'h1006);
        do_ack("R10");
        tick();

        // R6 R7 R3: every mask code against every level
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                i_mask = 3'(m);
                i_irq[l] = 1'b1; tick(); i_irq[l] = 1'b0; tick();
                if (l + 1 <= limit_of(m)) begin
                    expect_offer($sformatf("R6 R3 mask %0d level %0d", m, l + 1), lvl_vec[l]);
                end else begin
                    chk($sformatf("R6 mask %0d blocks level %0d", m, l + 1),
                        16'(o_vec_valid), 16'h0);
                    tick();
                    chk("R7 masked stays hidden", 16'(o_vec_valid), 16'h0);
                    i_mask = 3'd0;
                    tick();
                    expect_offer($sformatf("R7 released level %0d", l + 1), lvl_vec[l]);
                end
                do_ack("R10");
                tick();
            end
        end
        i_mask = 3'd0;

        // R5 R10: every pair of levels raised together
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                i_irq[a] = 1'b1; i_irq[b] = 1'b1; tick();
                i_irq = '0; tick();
                expect_offer($sformatf("R5 pair %0d/%0d first", a + 1, b + 1), lvl_vec[a]);
                do_ack("R10");
                tick();
                expect_offer($sformatf("R10 pair %0d/%0d second", a + 1, b + 1), lvl_vec[b]);
                do_ack("R10");
                tick();
            end
        end

        // R4: non-maskable order, mask ignored
        i_mask = 3'd7;
        i_nmi = 1'b1; i_illegal = 1'b1; i_wdt = 1'b1; i_irq[0] = 1'b1; tick();
        i_nmi = 1'b0; i_illegal = 1'b0; i_wdt = 1'b0; i_irq[0] = 1'b0; tick();
        expect_offer("R4 nmi first", 16'h101E);
        do_ack("R4"); tick();
        expect_offer("R4 illegal second", 16'h101E);
        do_ack("R4"); tick();
        expect_offer("R4 watchdog third", 16'h101C);
        do_ack("R4"); tick();
        expect_offer("R4 level 1 last", 16'h1000);
        do_ack("R4"); tick();
        chk("R4 nothing left", 16'(o_vec_valid), 16'h0);

        // R9: late higher request does not disturb an offer
        i_mask = 3'd0;
        i_irq[7] = 1'b1; tick(); i_irq[7] = 1'b0; tick();
        expect_offer("R9 initial offer", 16'h101A);
        i_nmi = 1'b1; tick(); i_nmi = 1'b0; tick(); tick();
        expect_offer("R9 offer frozen", 16'h101A);
        do_ack("R9"); tick();
        expect_offer("R9 nmi after retire", 16'h101E);
        do_ack("R9"); tick();

        // R11: ack with no offer leaves a masked request pending
        i_mask = 3'd7;
        i_irq[4] = 1'b1; tick(); i_irq[4] = 1'b0; tick();
        chk("R11 masked request not offered", 16'(o_vec_valid), 16'h0);
        i_ack = 1'b1; tick(); i_ack = 1'b0;
        i_mask = 3'd0; tick();
        expect_offer("R11 survives stray ack", 16'h100E);
        do_ack("R11"); tick();

        // R12: held line gives one offer
        i_irq[3] = 1'b1; tick(); tick();
        expect_offer("R12 held line offered", 16'h1008);
        do_ack("R12");
        tick(); tick(); tick(); tick();
        chk("R12 no repeat while held", 16'(o_vec_valid), 16'h0);
        i_irq[3] = 1'b0; tick();
        i_irq[3] = 1'b1; tick(); i_irq[3] = 1'b0; tick();
        expect_offer("R12 new edge offered", 16'h1008);
        do_ack("R12"); tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule